// File: doc/BRIEF.md
# Pixel Word Serializer with Sequence Tag

This block turns one parallel pixel per pixel period into a 24-bit transfer word and shifts that word out on two data lanes over six link-clock cycles. Each lane carries two bits per link cycle: one for the rising half and one for the falling half of the link clock. The word holds 18 colour bits, the three timing strobes (horizontal sync, vertical sync, data enable), one odd-parity bit and a 2-bit tag that counts up by one with every word. A receiver can use that tag, which always sits at the head of lane 1, to find word alignment without any line coding.

The block runs entirely on the link clock, which is six times the pixel rate. While `link_en` is low the lanes stay at zero and the tag stays cleared. At the first link edge where `link_en` is seen high, the block samples the pixel bus and starts a word. After that it samples the next pixel every sixth edge, so words follow each other with no gap. For colour depths below 18 bits, `depth_sel` zeroes the low bits of each channel, and the colour data is expected in the upper bits. The physical double-edge drivers and the clock multiplier sit outside the block.

Top module: `pixel_word_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the cycle after that edge shows both lane outputs at zero and `word_start` low, even if `link_en` is high.
- R2: At a rising edge where `link_en` is low, the block aborts any word in flight. From the next cycle the lanes read zero and `word_start` is low, and changes on the pixel inputs have no effect.
- R3: The first word loads at the first edge where `link_en` is seen high after it was low. Later words load every sixth edge. `word_start` is high only in the first of the six cycles of each word.
- R4: Lane 0 carries red bit 5 down to red bit 0, then green bit 5 down to green bit 0. Within each cycle, bit [1] of a lane output is the rising-half slot and bit [0] is the falling-half slot, which comes later. Red is `pix_rgb[17:12]`, green is `[11:6]` and blue is `[5:0]`.
- R5: Lane 1 carries tag bit 1 and tag bit 0 in the first cycle. Then come blue bit 5 down to blue bit 0, then HS, VS, DE, and last the parity bit.
- R6: The parity bit makes the number of ones across the 18 colour bits (after masking), HS, VS, DE and parity odd. The tag bits are not part of the parity.
- R7: The tag is 0 in the first word after activation and increases by one with every later word, wrapping from 3 to 0.
- R8: `depth_sel` value n (0 to 3) forces the n least significant bits of each 6-bit channel to zero before the channel is sent or included in the parity.
- R9: The pixel inputs and `depth_sel` are sampled only at the edge that loads a word. Changing them during a word does not alter the bits still to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, six times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | High while the link is in its active phase |
| depth_sel | input | 2 | Number of channel LSBs to force to zero |
| pix_rgb | input | 18 | Pixel colour: red [17:12], green [11:6], blue [5:0] |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| lane0_bits | output | 2 | Lane 0 slots for this cycle: [1] rising half, [0] falling half |
| lane1_bits | output | 2 | Lane 1 slots for this cycle: [1] rising half, [0] falling half |
| word_start | output | 1 | High in the first cycle of each word |

## Verification
Pixel values and `depth_sel` are driven before the load edge. Slot k of a word (k = 0 to 5) appears on the lanes during the cycle after the k-th edge following the load edge, because one shift register sits between the inputs and the lanes. The bench therefore samples once per cycle at the falling clock edge, starting right after the load edge, and rebuilds both 12-bit lane streams and the 6-bit `word_start` pattern before comparing them with values built from the requirements. Deactivation and reset take effect one edge after they are seen, so their checks sample at the first falling edge after that edge and keep checking on the falling edges that follow.

// File: rtl/pws_pkg.sv
// Shared types for the pixel word serializer.
package pws_pkg;
    // Number of low bits per colour channel forced to zero.
    typedef enum logic [1:0] {
        DEPTH_FULL = 2'd0,
        DEPTH_DROP1 = 2'd1,
        DEPTH_DROP2 = 2'd2,
        DEPTH_DROP3 = 2'd3
    } depth_e;
endpackage

// File: rtl/pws_phase_ctrl.sv
// Phase controller: tracks the active state of the link, the position
// inside the current word and the rolling tag.
// Assumes link_en is synchronous to clk. A word loads at the first edge
// where link_en is high, and again each time the phase wraps.
module pws_phase_ctrl #(
    parameter int WORD_CYC = 6,
    parameter int TAG_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        link_en,
    output logic                        act_q,
    output logic [$clog2(WORD_CYC)-1:0] phase_q,
    output logic                        load,
    output logic [TAG_W-1:0]            tag_q
);
    localparam int PH_W = $clog2(WORD_CYC);
    localparam logic [PH_W-1:0] LAST = PH_W'(WORD_CYC - 1);

    // Load decision: start of activity or end of the current word.
    always_comb begin
        load = link_en && (!act_q || phase_q == LAST);
    end

    // Active flag follows link_en one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= link_en;
    end

    // Phase counter: restarts at each load and is held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) phase_q <= '0;
        else if (load)          phase_q <= '0;
        else                    phase_q <= phase_q + 1'b1;
    end

    // Tag counter: steps once per word and clears while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) tag_q <= '0;
        else if (load)          tag_q <= tag_q + 1'b1;
    end

    // R3: the phase never leaves its range.
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);

    // R3: after the last phase of an active word, the next word begins.
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && link_en && phase_q == LAST) |=> (phase_q == '0 && act_q));

    // R7: each load moves the tag on by exactly one.
    p_tag_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tag_q == $past(tag_q) + 1'b1));
endmodule

// File: rtl/pws_word_pack.sv
// Word packer: masks the colour channels to the selected depth, computes
// odd parity and arranges the 24 bits into two per-lane slot streams.
// Purely combinational. Slot 0 of each lane stream is its MSB.
module pws_word_pack
    import pws_pkg::*;
#(
    parameter int CH_BITS  = 6,
    parameter int TAG_W    = 2,
    parameter int WORD_CYC = 6
) (
    input  logic [3*CH_BITS-1:0] rgb_i,
    input  logic                 hs_i,
    input  logic                 vs_i,
    input  logic                 de_i,
    input  depth_e               depth_i,
    input  logic [TAG_W-1:0]     tag_i,
    output logic [3*CH_BITS-1:0] rgb_masked_o,
    output logic                 par_o,
    output logic [2*WORD_CYC-1:0] lane0_o,
    output logic [2*WORD_CYC-1:0] lane1_o
);
    localparam int PIX_W = 3 * CH_BITS;

    // Depth masking: clear the low depth_i bits of each channel.
    always_comb begin
        for (int i = 0; i < PIX_W; i++) begin
            rgb_masked_o[i] = rgb_i[i] && ((i % CH_BITS) >= int'(depth_i));
        end
    end

    // Odd parity over the masked colour bits and the three strobes.
    always_comb begin
        par_o = ~^{rgb_masked_o, hs_i, vs_i, de_i};
    end

    // Lane arrangement: red then green on lane 0; tag, blue, strobes, parity on lane 1.
    always_comb begin
        lane0_o = rgb_masked_o[PIX_W-1 -: 2*CH_BITS];
        lane1_o = {tag_i, rgb_masked_o[CH_BITS-1:0], hs_i, vs_i, de_i, par_o};
    end
endmodule

// File: rtl/pws_lane_shift.sv
// Lane shifter: holds one lane's word and presents two slots per cycle,
// the rising-half slot in bit [1]. Shifts by two slots each active cycle.
module pws_lane_shift #(
    parameter int LANE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 load,
    input  logic                 shift,
    input  logic [LANE_BITS-1:0] din,
    output logic [1:0]           dout
);
    logic [LANE_BITS-1:0] sr_q;

    // Shift register: clear, load a word, or advance by one cycle's slots.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sr_q <= '0;
        else if (load)     sr_q <= din;
        else if (shift)    sr_q <= {sr_q[LANE_BITS-3:0], 2'b00};
    end

    // Current slot pair.
    always_comb begin
        dout = sr_q[LANE_BITS-1 -: 2];
    end
endmodule

// File: rtl/pixel_word_serializer.sv
// Pixel word serializer top: samples one pixel per word on the link
// clock and emits it over two lanes, two slots per lane per cycle.
// Assumes the link clock runs at WORD_CYC times the pixel rate and that
// all inputs are synchronous to clk.
module pixel_word_serializer
    import pws_pkg::*;
#(
    parameter int CH_BITS  = 6,
    parameter int TAG_W    = 2,
    parameter int WORD_CYC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_en,
    input  logic [1:0]           depth_sel,
    input  logic [3*CH_BITS-1:0] pix_rgb,
    input  logic                 pix_hs,
    input  logic                 pix_vs,
    input  logic                 pix_de,
    output logic [1:0]           lane0_bits,
    output logic [1:0]           lane1_bits,
    output logic                 word_start
);
    localparam int PIX_W     = 3 * CH_BITS;
    localparam int LANE_BITS = 2 * WORD_CYC;
    localparam int PH_W      = $clog2(WORD_CYC);
    localparam int N_LANES   = 2;

    logic                 act_q;
    logic [PH_W-1:0]      phase_q;
    logic                 load;
    logic [TAG_W-1:0]     tag_q;
    logic [PIX_W-1:0]     rgb_masked;
    logic                 par;
    logic [LANE_BITS-1:0] lane_word [N_LANES];
    logic [1:0]           lane_out  [N_LANES];

    pws_phase_ctrl #(.WORD_CYC(WORD_CYC), .TAG_W(TAG_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_en (link_en),
        .act_q   (act_q),
        .phase_q (phase_q),
        .load    (load),
        .tag_q   (tag_q)
    );

    pws_word_pack #(.CH_BITS(CH_BITS), .TAG_W(TAG_W), .WORD_CYC(WORD_CYC)) u_pack (
        .rgb_i        (pix_rgb),
        .hs_i         (pix_hs),
        .vs_i         (pix_vs),
        .de_i         (pix_de),
        .depth_i      (depth_e'(depth_sel)),
        .tag_i        (tag_q),
        .rgb_masked_o (rgb_masked),
        .par_o        (par),
        .lane0_o      (lane_word[0]),
        .lane1_o      (lane_word[1])
    );

    // One shifter per lane.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        pws_lane_shift #(.LANE_BITS(LANE_BITS)) u_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!link_en),
            .load  (load),
            .shift (act_q),
            .din   (lane_word[g]),
            .dout  (lane_out[g])
        );
    end

    // Output mapping and word-start marker.
    always_comb begin
        lane0_bits = lane_out[0];
        lane1_bits = lane_out[1];
        word_start = act_q && (phase_q == '0);
    end

    // R2: an idle link leaves the lanes quiet one edge later.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (lane0_bits == 2'b00 && lane1_bits == 2'b00 && !word_start));

    // R3: two word starts are never adjacent.
    p_word_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !word_start);

    // R6: the parity bit together with the 21 data bits holds an odd number of ones.
    p_parity_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({rgb_masked, pix_hs, pix_vs, pix_de, par}) % 2) == 1);

    // R8: with any reduced depth, the red channel LSB is zero.
    p_depth_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_sel != 2'd0) |-> !rgb_masked[2*CH_BITS]);
endmodule

// File: tb/pixel_word_serializer_test.sv
`timescale 1ns/1ps
module pixel_word_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        link_en;
    logic [1:0]  depth_sel;
    logic [17:0] pix_rgb;
    logic        pix_hs, pix_vs, pix_de;
    logic [1:0]  lane0_bits, lane1_bits;
    logic        word_start;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [1:0] tag_exp;

    always #4 clk = ~clk;

    pixel_word_serializer uut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .depth_sel(depth_sel),
        .pix_rgb(pix_rgb), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
        .lane0_bits(lane0_bits), .lane1_bits(lane1_bits), .word_start(word_start)
    );

    // Vector: {rgb, hs, vs, de, depth, expected masked rgb}
    localparam int NV = 8;
    localparam logic [40:0] VEC [NV] = '{
        {18'h3FFFF, 1'b1, 1'b1, 1'b1, 2'd0, 18'h3FFFF},
        {18'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 18'h00000},
        {18'h2AAAA, 1'b0, 1'b1, 1'b1, 2'd0, 18'h2AAAA},
        {18'h3FFFF, 1'b0, 1'b0, 1'b1, 2'd1, 18'h3EFBE},
        {18'h3FFFF, 1'b1, 1'b0, 1'b0, 2'd2, 18'h3CF3C},
        {18'h3FFFF, 1'b0, 1'b1, 1'b0, 2'd3, 18'h38E38},
        {18'h15555, 1'b1, 1'b0, 1'b0, 2'd0, 18'h15555},
        {18'h0F0F0, 1'b0, 1'b0, 1'b1, 2'd2, 18'h0C030}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Send one word (called at a falling edge), sample six slots, compare.
    task automatic send_word(input logic [17:0] rgb, input logic hs, input logic vs,
                             input logic de, input logic [1:0] dep,
                             input logic [17:0] masked, input bit disturb);
        logic [11:0] got0, got1, exp0, exp1;
        logic [5:0]  ws;
        logic        p;
        pix_rgb = rgb; pix_hs = hs; pix_vs = vs; pix_de = de; depth_sel = dep;
        got0 = '0; got1 = '0; ws = '0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            got0 = {got0[9:0], lane0_bits};
            got1 = {got1[9:0], lane1_bits};
            ws   = {ws[4:0], word_start};
            if (disturb && k == 2) begin
                pix_rgb = ~pix_rgb; pix_hs = ~pix_hs; pix_vs = ~pix_vs;
                pix_de = ~pix_de; depth_sel = ~depth_sel;
            end
        end
        p    = ~^{masked, hs, vs, de};
        exp0 = masked[17:6];
        exp1 = {tag_exp, masked[5:0], hs, vs, de, p};
        // R4 R8 R9: lane 0 red/green order with masking, unaffected by mid-word changes
        check(got0 == exp0, "R4/R8/R9 lane0", 32'(got0), 32'(exp0));
        // R5 R6 R7: lane 1 tag, blue, strobes, odd parity
        check(got1 == exp1, "R5/R6/R7 lane1", 32'(got1), 32'(exp1));
        // R3: word_start only in the first cycle
        check(ws == 6'b100000, "R3 word_start", 32'(ws), 32'h20);
        tag_exp = tag_exp + 2'd1;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        rst_n = 1'b0; link_en = 1'b0; depth_sel = 2'd0;
        pix_rgb = '0; pix_hs = 1'b0; pix_vs = 1'b0; pix_de = 1'b0;
        tag_exp = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(lane0_bits == 0 && lane1_bits == 0 && !word_start, "R1 reset",
              32'({lane0_bits, lane1_bits, word_start}), 32'h0);
        rst_n = 1'b1;
        pix_rgb = 18'h3FFFF; pix_hs = 1'b1; pix_vs = 1'b1; pix_de = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R2: idle link ignores pixel inputs
        check(lane0_bits == 0 && lane1_bits == 0 && !word_start, "R2 idle",
              32'({lane0_bits, lane1_bits, word_start}), 32'h0);

        // Table walk: continuous stream, tag 0..3 twice (R7 wrap), disturb on vector 6 (R9)
        link_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            send_word(VEC[i][40:23], VEC[i][22], VEC[i][21], VEC[i][20],
                      VEC[i][19:18], VEC[i][17:0], i == 6);
        end

        // R2: abort mid-word
        pix_rgb = 18'h2AAAA;
        @(posedge clk);
        @(negedge clk);
        link_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(lane0_bits == 0 && lane1_bits == 0 && !word_start, "R2 abort",
                  32'({lane0_bits, lane1_bits, word_start}), 32'h0);
            pix_rgb = pix_rgb ^ 18'h3FFFF; pix_de = ~pix_de;
        end

        // R7 R3: reactivation restarts the tag at zero
        tag_exp = 2'd0;
        link_en = 1'b1;
        send_word(18'h3FFFF, 1'b0, 1'b0, 1'b1, 2'd0, 18'h3FFFF, 1'b0);
        send_word(18'h00FC0, 1'b1, 1'b1, 1'b0, 2'd0, 18'h00FC0, 1'b0);

        // R1: reset while active
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(lane0_bits == 0 && lane1_bits == 0 && !word_start, "R1 reset active",
              32'({lane0_bits, lane1_bits, word_start}), 32'h0);
        rst_n = 1'b1;
        link_en = 1'b0;
        repeat (2) @(posedge clk);
        report();
    end
endmodule